// File: doc/BRIEF.md
# Board Interrupt Level Aggregator

This block gathers thirteen level-sensitive interrupt lines from the peripherals on a board and reduces them to a single 4-bit interrupt level code for the CPU. Each line owns one bit of a 16-bit status word and carries its own fixed priority level. The bit positions and the priority levels follow no common order. Software enables lines through a 16-bit mask. Among the lines that are both active and enabled, the one with the numerically smallest level wins. The code driven to the CPU is that level with all four bits inverted, so an idle system presents code 0.

Alongside the encoder, the block provides a small 16-bit register window of 64 bytes on a simple bus. The bus has a byte offset, a write strobe, write data and combinational read data. The window holds the mask, a general-purpose output latch, a fixed version word and a power-off control. Writing a 1 to bit 0 of the power-off control raises a one-cycle shutdown request. All other offsets read as zero and ignore writes.

Top module: `irl_hub`

## Requirements
- R1: Each source index maps to a fixed status-bit position and priority level, given here as index:bit/level. The sources are 0:9/1, 1:8/2, 2:14/9, 3:13/10, 4:12/3, 5:11/0, 6:10/4, 7:6/5, 8:5/6, 9:4/7, 10:7/8, 11:0/11 and 12:15/12.
- R2: Inputs are level-sensitive. The code reflects the input values present at a rising clock edge from that edge on. A source whose line falls stops contributing at the next edge.
- R3: A source competes only when its status bit and the same bit of the mask are both 1.
- R4: The competing source with the lowest level wins, and `irl_code` equals that level XOR 15. When nothing competes, the selected level is 15 and `irl_code` is 0.
- R5: Offset 0x00 is the mask. It is read/write, and a write takes part in the code computed at the same edge that stores it.
- R6: Offset 0x36 is an output latch. It is read/write, and it reads back the last value written.
- R7: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R8: Offset 0x30 reads 0. A write with bit 0 set drives `shutdown_req` high for exactly the one cycle after that write edge. A write with bit 0 clear produces no pulse.
- R9: Every other offset reads 0, and writes to such offsets change no register.
- R10: While `rst_n` is low, the mask, the latch, `irl_code` and `shutdown_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one 16-bit write per asserted edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_src | input | 13 | Level interrupt lines, indexed as in R1 |
| irl_code | output | 4 | Inverted winning level |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The bench drives each source alone under a full mask. A design with a wrong bit or level entry would present the wrong code for that source. It then raises every line at once, so a design that picked by bit position instead of level would not output 15. After that it lowers the lines one by one, which catches a status bit that stays set. Mask writes change the code in the same cycle as the write, so a design that did not forward the new mask would lag by one cycle. Writes to the version word and to unused offsets are followed by reads, which expose any leaked storage. Power-off writes with bit 0 clear and with bit 0 set check that the pulse lasts exactly one cycle. A long run with pseudo-random inputs and mask writes is compared against the reference model on every clock.

// File: rtl/irl_hub_pkg.sv
package irl_hub_pkg;
  localparam int unsigned HUB_NSRC = 13;
  localparam int unsigned HUB_DW   = 16;
  localparam int unsigned HUB_AW   = 6;
  localparam int unsigned HUB_LW   = 4;

  localparam logic [5:0] OFS_MASK = 6'h00;
  localparam logic [5:0] OFS_PWR  = 6'h30;
  localparam logic [5:0] OFS_VER  = 6'h32;
  localparam logic [5:0] OFS_PORT = 6'h36;

  localparam logic [15:0] VERSION_WORD = 16'h0010;

  // status-bit position owned by each source index
  function automatic int unsigned src_bit(input int unsigned idx);
    case (idx)
      0:       return 9;
      1:       return 8;
      2:       return 14;
      3:       return 13;
      4:       return 12;
      5:       return 11;
      6:       return 10;
      7:       return 6;
      8:       return 5;
      9:       return 4;
      10:      return 7;
      11:      return 0;
      12:      return 15;
      default: return 1;
    endcase
  endfunction

  // priority level of each source index (smaller wins)
  function automatic int unsigned src_level(input int unsigned idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 9;
      3:       return 10;
      4:       return 3;
      5:       return 0;
      6:       return 4;
      7:       return 5;
      8:       return 6;
      9:       return 7;
      10:      return 8;
      11:      return 11;
      12:      return 12;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/irl_src_map.sv
module irl_src_map
  import irl_hub_pkg::*;
#(
  parameter int unsigned NSRC = HUB_NSRC,
  parameter int unsigned DW   = HUB_DW
) (
  input  logic [NSRC-1:0] src,
  output logic [DW-1:0]   status
);
  // scatter each line onto its own status bit
  always_comb begin
    status = '0;
    for (int unsigned i = 0; i < NSRC; i++) begin
      status[src_bit(i)] = src[i];
    end
  end
endmodule

// File: rtl/irl_prio_enc.sv
module irl_prio_enc
  import irl_hub_pkg::*;
#(
  parameter int unsigned NSRC = HUB_NSRC,
  parameter int unsigned DW   = HUB_DW,
  parameter int unsigned LW   = HUB_LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] mask,
  output logic [LW-1:0] win_level
);
  localparam int unsigned NLEV = 1 << LW;

  logic [DW-1:0]   elig;
  logic [NLEV-1:0] lvl_hit;
  logic [NLEV-1:0] grant;

  assign elig = status & mask;

  // one OR term per level, collecting every source that sits on it
  for (genvar gl = 0; gl < NLEV; gl++) begin : g_lvl
    logic term;
    always_comb begin
      term = 1'b0;
      for (int unsigned i = 0; i < NSRC; i++) begin
        if (src_level(i) == gl) term = term | elig[src_bit(i)];
      end
    end
    assign lvl_hit[gl] = term;
  end

  // lowest set level wins; the top level doubles as the idle value
  assign grant = lvl_hit & ~(lvl_hit - NLEV'(1));

  always_comb begin
    win_level = LW'(NLEV - 1);
    for (int i = NLEV - 1; i >= 0; i--) begin
      if (grant[i]) win_level = LW'(i);
    end
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_no_grant_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> (grant == '0));
endmodule

// File: rtl/irl_regfile.sv
module irl_regfile
  import irl_hub_pkg::*;
#(
  parameter int unsigned DW = HUB_DW,
  parameter int unsigned AW = HUB_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] mask_d,
  output logic          shut_q
);
  logic [DW-1:0] port_q, port_d;
  logic          shut_d;
  logic          hit_mask, hit_port, hit_pwr, hit_ver;

  assign hit_mask = (addr == AW'(OFS_MASK));
  assign hit_port = (addr == AW'(OFS_PORT));
  assign hit_pwr  = (addr == AW'(OFS_PWR));
  assign hit_ver  = (addr == AW'(OFS_VER));

  // next-state
  always_comb begin
    mask_d = mask_q;
    port_d = port_q;
    shut_d = 1'b0;
    if (wr && hit_mask) mask_d = wdata;
    if (wr && hit_port) port_d = wdata;
    if (wr && hit_pwr)  shut_d = wdata[0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      port_q <= '0;
      shut_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      port_q <= port_d;
      shut_q <= shut_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (hit_mask) rdata = mask_q;
    if (hit_port) rdata = port_q;
    if (hit_ver)  rdata = DW'(VERSION_WORD);
  end

  assert_mask_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit_mask) |=> $stable(mask_q));
  assert_port_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit_port) |=> $stable(port_q));
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && !(wr && hit_pwr && wdata[0])) |=> !shut_q);
endmodule

// File: rtl/irl_hub.sv
module irl_hub
  import irl_hub_pkg::*;
#(
  parameter int unsigned NSRC = HUB_NSRC,
  parameter int unsigned DW   = HUB_DW,
  parameter int unsigned AW   = HUB_AW,
  parameter int unsigned LW   = HUB_LW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] irq_src,
  output logic [LW-1:0]   irl_code,
  output logic            shutdown_req
);
  localparam logic [LW-1:0] LVL_ALL = '1;

  logic [DW-1:0] status;
  logic [DW-1:0] mask_q, mask_d;
  logic [LW-1:0] win_level;
  logic [LW-1:0] irl_d, irl_q;
  logic          irl_en;

  irl_src_map #(.NSRC(NSRC), .DW(DW)) u_map (
    .src    (irq_src),
    .status (status)
  );

  irl_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .mask_q (mask_q),
    .mask_d (mask_d),
    .shut_q (shutdown_req)
  );

  // the mask about to be stored takes part in this edge's decision
  irl_prio_enc #(.NSRC(NSRC), .DW(DW), .LW(LW)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (status),
    .mask      (mask_d),
    .win_level (win_level)
  );

  assign irl_en = 1'b1;
  assign irl_d  = win_level ^ LVL_ALL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irl_q <= '0;
    else if (irl_en) irl_q <= irl_d;
  end

  assign irl_code = irl_q;

  assert_code_needs_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irl_code != '0) |-> $past((status & mask_d) != '0));
  assert_shutdown_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_req) |-> $past(bus_wr && bus_addr == AW'(OFS_PWR) && bus_wdata[0]));
endmodule

// File: tb/sim_irl_hub.sv
`timescale 1ns/1ps
module sim_irl_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [12:0] irq_src;
  logic [3:0]  irl_code;
  logic        shutdown_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int          bitpos [13];
  int          lvl    [13];
  logic [15:0] m_mask, m_port;
  logic [3:0]  m_irl;
  logic        m_sd;
  int unsigned lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  irl_hub u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irl_code(irl_code), .shutdown_req(shutdown_req)
  );

  function automatic logic [3:0] model_code(logic [12:0] s, logic [15:0] mk);
    int best = 15;
    for (int i = 0; i < 13; i++)
      if (s[i] && mk[bitpos[i]] && lvl[i] < best) best = lvl[i];
    return 4'(best) ^ 4'hF;
  endfunction

  function automatic logic [15:0] model_read(logic [5:0] a);
    if (a == 6'h00) return m_mask;
    if (a == 6'h36) return m_port;
    if (a == 6'h32) return 16'h0010;
    return 16'h0000;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step(string tag);
    logic [15:0] nm;
    @(posedge clk);
    nm = (bus_wr && bus_addr == 6'h00) ? bus_wdata : m_mask;
    m_irl = model_code(irq_src, nm);
    m_sd  = bus_wr && bus_addr == 6'h30 && bus_wdata[0];
    if (bus_wr && bus_addr == 6'h36) m_port = bus_wdata;
    m_mask = nm;
    @(negedge clk);
    chk(tag, "irl_code", irl_code, m_irl);
    chk(tag, "shutdown_req", shutdown_req, m_sd);
    chk(tag, "bus_rdata", bus_rdata, model_read(bus_addr));
  endtask

  task automatic wr(string tag, logic [5:0] a, logic [15:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    step(tag);
    bus_wr = 1'b0;
    step(tag);
  endtask

  task automatic rd(string tag, logic [5:0] a, logic [15:0] exp);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    chk(tag, "readback", bus_rdata, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 table
    bitpos = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};
    lvl    = '{1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12};
    m_mask = '0; m_port = '0; m_irl = '0; m_sd = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; irq_src = '0;
    repeat (3) @(negedge clk);
    // R10: reset values, held while reset is low even with inputs active
    irq_src = '1;
    @(negedge clk);
    chk("R10", "irl_code in reset", irl_code, 0);
    chk("R10", "shutdown_req in reset", shutdown_req, 0);
    chk("R10", "mask in reset", bus_rdata, 0);
    rd("R10", 6'h36, 16'h0000);
    irq_src = '0; bus_addr = 6'h00;
    rst_n = 1'b1;
    step("R10");

    // R1: each source alone under a full mask
    wr("R5", 6'h00, 16'hFFFF);
    for (int i = 0; i < 13; i++) begin
      irq_src = 13'(1) << i;
      step("R1");
      chk("R1", $sformatf("src %0d code", i), irl_code, (lvl[i] ^ 15));
    end
    // R4: all lines active, then drop them in turn (R2)
    irq_src = '1;
    step("R4");
    chk("R4", "all active", irl_code, 15);
    for (int i = 0; i < 13; i++) begin
      irq_src[i] = 1'b0;
      step("R2");
    end
    chk("R4", "nothing pending", irl_code, 0);

    // R3: mask off the winner, then everything
    irq_src = 13'h0021;            // sources 0 and 5: levels 1 and 0
    step("R3");
    chk("R3", "level 0 wins", irl_code, 15);
    wr("R3", 6'h00, 16'hF7FF);     // clear bit 11
    chk("R3", "masked winner", irl_code, 14);
    bus_addr = 6'h00; bus_wr = 1'b1; bus_wdata = 16'h0000;
    step("R5");
    chk("R5", "mask write acts same edge", irl_code, 0);
    bus_wr = 1'b0;
    step("R5");

    // R6 latch
    wr("R6", 6'h36, 16'hA55A);
    rd("R6", 6'h36, 16'hA55A);
    wr("R6", 6'h36, 16'h0F0F);
    rd("R6", 6'h36, 16'h0F0F);
    // R7 version
    wr("R7", 6'h32, 16'hFFFF);
    rd("R7", 6'h32, 16'h0010);
    // R9 unlisted offsets
    wr("R9", 6'h10, 16'hBEEF);
    wr("R9", 6'h02, 16'hBEEF);
    rd("R9", 6'h10, 16'h0000);
    rd("R9", 6'h3E, 16'h0000);
    rd("R9", 6'h36, 16'h0F0F);
    rd("R9", 6'h00, 16'h0000);
    // R8 power-off
    wr("R8", 6'h30, 16'h0000);
    wr("R8", 6'h30, 16'hFFFE);
    bus_addr = 6'h30; bus_wr = 1'b1; bus_wdata = 16'h0001;
    step("R8");
    chk("R8", "pulse high", shutdown_req, 1);
    bus_wr = 1'b0;
    step("R8");
    chk("R8", "pulse ends", shutdown_req, 0);
    rd("R8", 6'h30, 16'h0000);

    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      irq_src   = lfsr[12:0];
      bus_wr    = (lfsr[20:18] == 3'd0);
      bus_addr  = lfsr[21] ? 6'h00 : (lfsr[22] ? 6'h36 : 6'h30);
      bus_wdata = lfsr[31:16];
      step("R2");
    end
    bus_wr = 1'b0;
    step("R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule